// File: doc/BRIEF.md
# Two-Group Prioritized Interrupt Controller

This block collects up to fifteen interrupt request lines, numbered 1 to 15, and presents one 4-bit interrupt level to a processor. Each request line is synchronized and edge-detected. A rising request is recorded in a pending register. If the line is marked for broadcast, the request is recorded instead in the force register of every processor slot. Software reaches all state through a 32-bit register port with a 256-byte window. Only the low 8 address bits are decoded. Line 0 does not exist, so bit 0 of every interrupt vector is always zero.

For slot 0, the pending bits are combined with the slot's force bits and then gated by the slot's mask. A per-line priority register splits the enabled bits into a high group and a low group. If any high-group bit is enabled, the high group is the only one presented. The output level is the highest-numbered bit of the presented group. The processor acknowledges a serviced line by pulsing `ack_i` with that line's number. Mask, force and extended registers are replicated for a parameterized number of processor slots. Only slot 0 drives the output.

Top module: `irqc_top`

## Requirements
- R1: After reset, every register reads 0 and `irl_o` is 0.
- R2: Bit 0 is never stored. Writes to the priority, broadcast, mask and force registers keep only bits 15:1, so those registers read back with bit 0 and bits 31:16 at zero.
- R3: Word offsets decoded from `addr_i[7:0]` (upper address bits are ignored):
  - 0x00 priority
  - 0x04 pending
  - 0x08 slot-0 force alias
  - 0x0C clear
  - 0x10 status
  - 0x14 broadcast
  - 0x40+4s mask of slot s
  - 0x80+4s force of slot s
  - 0xC0+4s extended of slot s
- R4: Suppose input n is driven high just after a falling clock edge and its broadcast bit is 0. Pending bit n then reads 1 after the third rising edge. `irl_o` reflects the request after the fourth rising edge.
- R5: A rising input whose broadcast bit is 1 sets that bit in the force register of every slot and leaves pending unchanged.
- R6: The enabled set is (pending OR force of slot 0) AND mask of slot 0. Enabled bits whose priority bit is 1 form the high group, and the others form the low group. `irl_o` is the highest set bit number of the high group when that group is non-empty, otherwise of the low group, and 0 when nothing is enabled. It is registered, so it follows a register write or acknowledge one cycle later.
- R7: A write to a slot force register at 0x80+4s sets the bits in `wdata_i[15:1]` and clears the bits in `wdata_i[31:17]` (bit 16+n clears bit n). Clearing wins over setting. A write to the alias at 0x08 replaces the slot-0 force with `wdata_i[15:1]`.
- R8: A write to 0x0C clears the pending bits that are 1 in `wdata_i[15:1]`. Offsets 0x0C and 0x10 always read 0.
- R9: An `ack_i` pulse with number n = `ack_num_i[3:0]` clears bit n of pending and of slot-0 force. `ack_num_i[4]` is ignored.
- R10: Writes to the pending register at 0x04 have no effect.
- R11: Extended registers keep `wdata_i[3:0]`. Unmapped offsets, including slots at or above NUM_CPU, read 0 and ignore writes.
- R12: A request held high sets pending only once. After its pending bit is cleared, the bit stays clear until the input falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 16 | Request lines; bit 0 unused |
| ack_i | input | 1 | Acknowledge strobe |
| ack_num_i | input | 5 | Acknowledged line number; bits 3:0 used |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 32 | Register byte address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for `addr_i`, combinational |
| irl_o | output | 4 | Interrupt level presented to the processor |

## Verification
The assertions check several relations on every cycle:
- an acknowledge with no simultaneous new request leaves the pending bit clear;
- a non-empty high group always yields a nonzero level;
- an empty enabled set yields level 0;
- the clear and status offsets read zero;
- a pending write never adds bits;
- force clear bits take effect;
- a broadcast request reaches every slot.

The scenarios cover what the assertions do not:
- the exact latency from a request edge to pending and to `irl_o`;
- the choice of the highest line inside the selected group;
- bit-0 and upper-bit masking on write;
- ignoring of upper address bits and of `ack_num_i[4]`;
- extended and unmapped offsets;
- the held-request case.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int IRQ_W  = 16;
  localparam int LVL_W  = $clog2(IRQ_W);
  // word offsets (addr[7:2])
  localparam logic [5:0] W_PRIO   = 6'h00;
  localparam logic [5:0] W_PEND   = 6'h01;
  localparam logic [5:0] W_FALIAS = 6'h02;
  localparam logic [5:0] W_CLEAR  = 6'h03;
  localparam logic [5:0] W_STAT   = 6'h04;
  localparam logic [5:0] W_BCAST  = 6'h05;
  // slot regions (addr[7:6])
  localparam logic [1:0] RG_MASK  = 2'b01;
  localparam logic [1:0] RG_FORCE = 2'b10;
  localparam logic [1:0] RG_EXT   = 2'b11;
endpackage

// File: rtl/irqc_edge.sv
module irqc_edge #(
  parameter int W = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int W  = 16,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] irq_i,
  input  logic        ack_i,
  input  logic [4:0]  ack_num_i,
  input  logic        wr_en_i,
  input  logic [31:0] addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic [3:0]  irl_o
);
  localparam int SLOT_W = 4;

  logic unused_bits;
  assign unused_bits = ^{irq_i[0], ack_num_i[4], addr_i[31:8], addr_i[1:0], wdata_i[16]};

  // request capture
  logic [15:1] rise;
  irqc_edge #(.W(IRQ_W-1)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_i[15:1]),
    .rise_o(rise)
  );

  logic [15:1] prio_q, bcast_q, pend_q;
  logic [15:1] mask_q  [NUM_CPU];
  logic [15:1] force_q [NUM_CPU];
  logic [3:0]  ext_q   [NUM_CPU];
  logic [3:0]  irl_q;

  logic [15:1] pend_set, bcast_set;
  assign pend_set  = rise & ~bcast_q;
  assign bcast_set = rise &  bcast_q;

  // decode
  logic [5:0] word;
  logic [1:0] region;
  logic [SLOT_W-1:0] slot;
  assign word   = addr_i[7:2];
  assign region = addr_i[7:6];
  assign slot   = addr_i[5:2];

  logic wr_prio, wr_falias, wr_clear, wr_bcast;
  assign wr_prio   = wr_en_i && word == W_PRIO;
  assign wr_falias = wr_en_i && word == W_FALIAS;
  assign wr_clear  = wr_en_i && word == W_CLEAR;
  assign wr_bcast  = wr_en_i && word == W_BCAST;

  logic [NUM_CPU-1:0] wr_mask, wr_force, wr_ext;

  // acknowledge vector
  logic [15:0] ack_dec;
  logic [15:1] ack_vec, clr_vec;
  logic unused_ack;
  assign ack_dec    = 16'(1) << ack_num_i[3:0];
  assign unused_ack = ack_dec[0];
  assign ack_vec    = ack_i ? ack_dec[15:1] : '0;
  assign clr_vec    = wr_clear ? wdata_i[15:1] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q  <= '0;
      bcast_q <= '0;
      pend_q  <= '0;
    end else begin
      if (wr_prio)  prio_q  <= wdata_i[15:1];
      if (wr_bcast) bcast_q <= wdata_i[15:1];
      // clear and ack act first; a new edge in the same cycle survives
      pend_q <= (pend_q & ~clr_vec & ~ack_vec) | pend_set;
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_slot
    assign wr_mask[c]  = wr_en_i && region == RG_MASK  && slot == SLOT_W'(c);
    assign wr_force[c] = wr_en_i && region == RG_FORCE && slot == SLOT_W'(c);
    assign wr_ext[c]   = wr_en_i && region == RG_EXT   && slot == SLOT_W'(c);

    logic [15:1] force_nx;
    always_comb begin
      force_nx = force_q[c];
      if (c == 0 && wr_falias) force_nx = wdata_i[15:1];
      if (wr_force[c]) force_nx = (force_nx | wdata_i[15:1]) & ~wdata_i[31:17];
      if (c == 0) force_nx = force_nx & ~ack_vec;
      force_nx = force_nx | bcast_set;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_q[c]  <= '0;
        force_q[c] <= '0;
        ext_q[c]   <= '0;
      end else begin
        if (wr_mask[c]) mask_q[c] <= wdata_i[15:1];
        if (wr_ext[c])  ext_q[c]  <= wdata_i[3:0];
        force_q[c] <= force_nx;
      end
    end

    // R7: requested clear bits are gone after a slot force write
    assert_force_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_force[c] && bcast_set == '0 |=> (force_q[c] & $past(wdata_i[31:17])) == '0);
    // R5: broadcast request lands in every slot
    assert_bcast_all_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bcast_set != '0 |=> (force_q[c] & $past(bcast_set)) == $past(bcast_set));
  end

  // output selection for slot 0
  logic [15:1] active, hi_grp, lo_grp, sel_grp;
  logic [3:0]  lvl_nx;
  assign active  = (pend_q | force_q[0]) & mask_q[0];
  assign hi_grp  = active & prio_q;
  assign lo_grp  = active & ~prio_q;
  assign sel_grp = (|hi_grp) ? hi_grp : lo_grp;

  irqc_prio #(.W(IRQ_W)) u_prio (
    .vec_i({sel_grp, 1'b0}),
    .idx_o(lvl_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irl_q <= '0;
    else         irl_q <= lvl_nx;
  end
  assign irl_o = irl_q;

  // read mux
  always_comb begin
    rdata_o = '0;
    case (word)
      W_PRIO:   rdata_o = {16'b0, prio_q, 1'b0};
      W_PEND:   rdata_o = {16'b0, pend_q, 1'b0};
      W_FALIAS: rdata_o = {16'b0, force_q[0], 1'b0};
      W_BCAST:  rdata_o = {16'b0, bcast_q, 1'b0};
      default: begin
        for (int c = 0; c < NUM_CPU; c++) begin
          if (slot == SLOT_W'(c)) begin
            case (region)
              RG_MASK:  rdata_o = {16'b0, mask_q[c], 1'b0};
              RG_FORCE: rdata_o = {16'b0, force_q[c], 1'b0};
              RG_EXT:   rdata_o = {28'b0, ext_q[c]};
              default:  rdata_o = '0;
            endcase
          end
        end
      end
    endcase
  end

  logic [15:0] pend16, pset16;
  assign pend16 = {pend_q, 1'b0};
  assign pset16 = {pend_set, 1'b0};

  assert_ack_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && ack_num_i[3:0] != 4'd0 && !pset16[ack_num_i[3:0]]
    |=> !pend16[$past(ack_num_i[3:0])]);
  assert_hi_nonzero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hi_grp) |=> irl_o != 4'd0);
  assert_idle_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active == '0 |=> irl_o == 4'd0);
  assert_zero_reads_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word == W_CLEAR || word == W_STAT) |-> rdata_o == 32'd0);
  assert_pend_ro_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && word == W_PEND |=> (pend_q & ~$past(pend_q) & ~$past(pend_set)) == '0);
endmodule

// File: tb/irqc_top_test.sv
`timescale 1ns/1ps
module irqc_top_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] irq_i = '0;
  logic        ack_i = 1'b0;
  logic [4:0]  ack_num_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [3:0]  irl_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irqc_top #(.NUM_CPU(4)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq_i), .ack_i(ack_i),
    .ack_num_i(ack_num_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irl_o(irl_o)
  );

  typedef struct {
    bit          is_irl;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  // monitor
  initial begin
    forever begin
      item_t it;
      logic [31:0] act;
      wait (sb.size() > 0);
      it = sb.pop_front();
      act = it.is_irl ? {28'b0, irl_o} : rdata_o;
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic ack(input logic [4:0] n);
    @(negedge clk);
    ack_i = 1'b1; ack_num_i = n;
    @(negedge clk);
    ack_i = 1'b0;
  endtask

  task automatic chk_reg(input logic [31:0] a, input logic [31:0] e, input string tag);
    item_t it;
    addr_i = a;
    #1;
    it.is_irl = 1'b0; it.exp = e; it.tag = tag;
    sb.push_back(it);
    #0;
  endtask

  task automatic chk_irl(input logic [3:0] e, input string tag);
    item_t it;
    #1;
    it.is_irl = 1'b1; it.exp = {28'b0, e}; it.tag = tag;
    sb.push_back(it);
    #0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1
    chk_irl(4'd0, "R1 irl after reset");
    chk_reg(32'h00, 32'h0, "R1 prio reset");
    chk_reg(32'h04, 32'h0, "R1 pending reset");
    chk_reg(32'h40, 32'h0, "R1 mask reset");
    // R2
    wr(32'h40, 32'hFFFF_FFFF);
    chk_reg(32'h40, 32'h0000_FFFE, "R2 mask bit0/upper dropped");
    wr(32'h00, 32'h0000_0001);
    chk_reg(32'h00, 32'h0, "R2 prio bit0 dropped");
    // R4 latency
    @(negedge clk); irq_i[5] = 1'b1;
    repeat (3) @(negedge clk);
    chk_reg(32'h04, 32'h0000_0020, "R4 pending after third edge");
    chk_irl(4'd0, "R4 irl not yet");
    @(negedge clk);
    chk_irl(4'd5, "R4 irl after fourth edge");
    // R6 highest of low group
    irq_i[9] = 1'b1;
    repeat (4) @(negedge clk);
    chk_irl(4'd9, "R6 highest low bit");
    chk_reg(32'h04, 32'h0000_0220, "R4 pending two lines");
    // R6 high group wins
    wr(32'h00, 32'h0000_0020);
    chk_reg(32'h00, 32'h0000_0020, "R3 prio readback");
    @(negedge clk);
    chk_irl(4'd5, "R6 high group first");
    // R9 ack with bit4 set
    ack(5'd21);
    chk_reg(32'h04, 32'h0000_0200, "R9 ack cleared pending 5");
    @(negedge clk);
    chk_irl(4'd9, "R9 level after ack");
    // R12 held line does not re-set
    repeat (4) @(negedge clk);
    chk_reg(32'h04, 32'h0000_0200, "R12 held line stays clear");
    // R8 clear register
    wr(32'h0C, 32'h0000_0201);
    chk_reg(32'h04, 32'h0, "R8 pending cleared");
    chk_reg(32'h0C, 32'h0, "R8 clear reads zero");
    chk_reg(32'h10, 32'h0, "R8 status reads zero");
    @(negedge clk);
    chk_irl(4'd0, "R6 idle after clear");
    repeat (3) @(negedge clk);
    chk_reg(32'h04, 32'h0, "R12 held lines no new request");
    irq_i = '0;
    repeat (3) @(negedge clk);
    // R10
    wr(32'h04, 32'hFFFF_FFFF);
    chk_reg(32'h04, 32'h0, "R10 pending read-only");
    // R7 alias
    wr(32'h08, 32'hFFFF_0009);
    chk_reg(32'h08, 32'h0000_0008, "R7 alias replace");
    chk_reg(32'h80, 32'h0000_0008, "R7 alias equals slot0 force");
    @(negedge clk);
    chk_irl(4'd3, "R6 forced low group");
    // R7 slot force set/clear
    wr(32'h84, 32'h0000_0006);
    chk_reg(32'h84, 32'h0000_0006, "R7 slot1 set");
    wr(32'h84, 32'h0004_0010);
    chk_reg(32'h84, 32'h0000_0012, "R7 slot1 set and clear");
    wr(32'h84, 32'h0002_0002);
    chk_reg(32'h84, 32'h0000_0010, "R7 clear wins");
    // R5 broadcast
    wr(32'h14, 32'h0000_0081);
    chk_reg(32'h14, 32'h0000_0080, "R2 broadcast bit0 dropped");
    @(negedge clk); irq_i[7] = 1'b1;
    repeat (3) @(negedge clk);
    chk_reg(32'h04, 32'h0, "R5 pending untouched");
    chk_reg(32'h80, 32'h0000_0088, "R5 slot0 force");
    chk_reg(32'h84, 32'h0000_0090, "R5 slot1 force");
    chk_reg(32'h88, 32'h0000_0080, "R5 slot2 force");
    chk_reg(32'h8C, 32'h0000_0080, "R5 slot3 force");
    @(negedge clk);
    chk_irl(4'd7, "R5 broadcast reaches level");
    irq_i[7] = 1'b0;
    ack(5'd7);
    chk_reg(32'h80, 32'h0000_0008, "R9 ack clears slot0 force");
    chk_reg(32'h84, 32'h0000_0090, "R9 slot1 unaffected");
    @(negedge clk);
    chk_irl(4'd3, "R9 level after force ack");
    // R3 upper address bits ignored
    chk_reg(32'hFFFF_FF14, 32'h0000_0080, "R3 upper address ignored on read");
    wr(32'h1234_0040, 32'h0);
    chk_reg(32'h40, 32'h0, "R3 upper address ignored on write");
    @(negedge clk);
    chk_irl(4'd0, "R6 masked off");
    // R11
    wr(32'hC4, 32'hFFFF_FFFF);
    chk_reg(32'hC4, 32'h0000_000F, "R11 extended 4 bits");
    wr(32'h18, 32'hFFFF_FFFF);
    chk_reg(32'h18, 32'h0, "R11 unmapped offset");
    wr(32'h54, 32'hFFFF_FFFF);
    chk_reg(32'h54, 32'h0, "R11 slot beyond NUM_CPU");
    chk_reg(32'h40, 32'h0, "R11 slot write no alias");
    repeat (2) @(negedge clk);
    wait (sb.size() == 0);
    #1;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule